// File: doc/BRIEF.md
# Tagged Receive FIFO with End/Error Window

This block buffers received bytes for a serial link controller. A receiver front end pushes each byte together with three condition tags: end of frame, CRC error and receiver overrun. The block stores them as one entry. A host pops entries from the oldest end. The tags of the oldest entry are shown on three status flags at all times, so the host can inspect them before it removes the byte.

A window check looks at the four oldest valid entries. If any of them carries a tag, an end/error indication rises. That indication drives an interrupt and holds the receive DMA request low. The host then drains the tagged entries by hand. Once no tagged entry is left in the window, the DMA request returns to its level-based behaviour by itself.

The DMA request asserts when the occupancy reaches a configurable level. A push into a full FIFO is dropped and sets a sticky overflow flag. The deserializer, the CRC logic and the bus attachment lie outside this block.

Top module: `tagged_rx_fifo`

## Requirements
- R1: During and after a synchronous active-low reset, the FIFO is empty: `level` is 0, and `full`, `overflow`, `eif`, `irq`, `dma_req`, the three tag flags and `pop_byte` are all 0.
- R2: `pop_byte` shows bits 7..0 of the oldest entry. Entries leave in the order in which they were pushed, one per cycle with `pop_req` high.
- R3: An entry stores `push_tags[0]` as EOF (entry bit 8), `push_tags[1]` as CRC error (bit 9) and `push_tags[2]` as overrun (bit 10). `flag_eof`, `flag_crc` and `flag_ovr` show those bits of the oldest entry before it is popped. After a pop they show the tags of the next entry.
- R4: While the FIFO is empty, `pop_byte` and all three flags read 0. A pop request while empty leaves `level` at 0.
- R5: `eif` is high exactly when a tag bit is set in one of the oldest min(4, `level`) entries. A tagged entry further back does not raise it. The check uses the contents after each cycle's push and pop.
- R6: `irq` equals `eif`, and `dma_req` is low whenever `eif` is high.
- R7: `dma_req` is high exactly when `level` is at least DMA_LEVEL and `eif` is low. It resumes without host action once `eif` falls.
- R8: `full` is high when `level` equals DEPTH. A push while full, without a pop in the same cycle, is dropped and leaves the contents unchanged. It sets `overflow`, which stays high until reset.
- R9: A push and a pop in the same cycle are both honoured and leave `level` unchanged, including when the FIFO is full. On an empty FIFO only the push takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Store one entry this cycle |
| push_byte | input | 8 | Received data byte |
| push_tags | input | 3 | Tags: [0] end of frame, [1] CRC error, [2] overrun |
| pop_req | input | 1 | Remove the oldest entry this cycle |
| pop_byte | output | 8 | Data byte of the oldest entry (0 when empty) |
| flag_eof | output | 1 | End-of-frame tag of the oldest entry |
| flag_crc | output | 1 | CRC-error tag of the oldest entry |
| flag_ovr | output | 1 | Overrun tag of the oldest entry |
| eif | output | 1 | Tag present in the four oldest entries |
| irq | output | 1 | Interrupt, follows eif |
| dma_req | output | 1 | Receive DMA request |
| full | output | 1 | FIFO holds DEPTH entries |
| empty | output | 1 | FIFO holds no entries |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| overflow | output | 1 | Sticky: a push was dropped while full |

## Verification
The bench builds the block with DEPTH 8, a window of 4 and DMA_LEVEL 4. A depth of 8 keeps the window at half the storage. Filling, overflow and full push-and-pop can then be reached in a few cycles. It also leaves room to place a tagged entry just beyond the window and walk it into the window by popping. With a threshold of 4, the DMA request can be seen held off by a tagged entry and then resuming by itself within the same short sequence.

// File: rtl/rxq_pkg.sv
// Package: shared entry type for the tagged receive FIFO.
// Assumes tag bit 0 = end of frame, 1 = CRC error, 2 = overrun.
package rxq_pkg;
    localparam int TAG_W  = 3;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [TAG_W-1:0]  tags;   // entry bits 10..8
        logic [DATA_W-1:0] data;   // entry bits 7..0
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
// Module: rxq_store
// Circular storage with read/write pointers, occupancy, full/empty and
// a sticky overflow flag. It exposes the oldest WIN entries for the
// window check.
// Assumes DEPTH is a power of two and WIN <= DEPTH.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIN   = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_valid,
    input  rxq_entry_t            push_entry,
    input  logic                  pop_req,
    output rxq_entry_t [WIN-1:0]  win_q,
    output logic [CNT_W-1:0]      level,
    output logic                  full,
    output logic                  empty,
    output logic                  overflow
);
    rxq_entry_t        mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  wr_ptr;
    logic              do_pop;
    logic              do_push;

    assign empty   = (level == '0);
    assign full    = (level == CNT_W'(DEPTH));
    assign do_pop  = pop_req && !empty;
    assign do_push = push_valid && (!full || do_pop);

    // Write the incoming entry at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_entry;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            case ({do_push, do_pop})
                2'b10:   level <= level + CNT_W'(1);
                2'b01:   level <= level - CNT_W'(1);
                default: level <= level;
            endcase
        end
    end

    // Latch a dropped push into the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (push_valid && full && !do_pop) begin
            overflow <= 1'b1;
        end
    end

    // Present the oldest WIN slots, oldest at index 0.
    for (genvar i = 0; i < WIN; i++) begin : g_win
        assign win_q[i] = mem[rd_ptr + PTR_W'(i)];
    end
endmodule

// File: rtl/rxq_window.sv
// Module: rxq_window
// Raises eif when any valid slot among the oldest WIN carries a tag.
// Assumes win_q[0] is the oldest entry; slots at or past level are ignored.
module rxq_window
    import rxq_pkg::*;
#(
    parameter int WIN   = 4,
    parameter int CNT_W = 5
) (
    input  rxq_entry_t [WIN-1:0] win_q,
    input  logic [CNT_W-1:0]     level,
    output logic                 eif
);
    logic [WIN-1:0] slot_hit;

    // Flag each slot that is valid and tagged.
    for (genvar i = 0; i < WIN; i++) begin : g_slot
        assign slot_hit[i] = (CNT_W'(i) < level) && (|win_q[i].tags);
    end

    assign eif = |slot_hit;
endmodule

// File: rtl/rxq_req.sv
// Module: rxq_req
// Builds the interrupt and the level-based DMA request, gated by eif.
// Assumes level and eif reflect the current stored contents.
module rxq_req #(
    parameter int DMA_LEVEL = 8,
    parameter int CNT_W     = 5
) (
    input  logic [CNT_W-1:0] level,
    input  logic             eif,
    output logic             irq,
    output logic             dma_req
);
    // Interrupt follows eif; DMA needs enough data and no tag in the window.
    always_comb begin
        irq     = eif;
        dma_req = (level >= CNT_W'(DMA_LEVEL)) && !eif;
    end
endmodule

// File: rtl/tagged_rx_fifo.sv
// Module: tagged_rx_fifo (top)
// Receive FIFO of byte+tag entries. It shows the oldest entry's tags as
// flags, checks the oldest WIN entries for tags, and gates DMA with that check.
// Assumes DEPTH is a power of two, WIN <= DEPTH, DMA_LEVEL <= DEPTH.
module tagged_rx_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int WIN       = 4,
    parameter int DMA_LEVEL = 8,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [7:0]       push_byte,
    input  logic [2:0]       push_tags,
    input  logic             pop_req,
    output logic [7:0]       pop_byte,
    output logic             flag_eof,
    output logic             flag_crc,
    output logic             flag_ovr,
    output logic             eif,
    output logic             irq,
    output logic             dma_req,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] level,
    output logic             overflow
);
    rxq_entry_t           push_entry;
    rxq_entry_t [WIN-1:0] win_q;
    rxq_entry_t           bottom;

    assign push_entry.tags = push_tags;
    assign push_entry.data = push_byte;

    rxq_store #(.DEPTH(DEPTH), .WIN(WIN)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_entry (push_entry),
        .pop_req    (pop_req),
        .win_q      (win_q),
        .level      (level),
        .full       (full),
        .empty      (empty),
        .overflow   (overflow)
    );

    rxq_window #(.WIN(WIN), .CNT_W(CNT_W)) u_window (
        .win_q (win_q),
        .level (level),
        .eif   (eif)
    );

    rxq_req #(.DMA_LEVEL(DMA_LEVEL), .CNT_W(CNT_W)) u_req (
        .level   (level),
        .eif     (eif),
        .irq     (irq),
        .dma_req (dma_req)
    );

    // Oldest entry, forced to zero while empty.
    always_comb begin
        bottom   = empty ? '0 : win_q[0];
        pop_byte = bottom.data;
        flag_eof = bottom.tags[0];
        flag_crc = bottom.tags[1];
        flag_ovr = bottom.tags[2];
    end
endmodule

// Checker: port-level properties of tagged_rx_fifo.
module tagged_rx_fifo_chk #(
    parameter int DEPTH     = 16,
    parameter int DMA_LEVEL = 8,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             pop_req,
    input logic [7:0]       pop_byte,
    input logic             flag_eof,
    input logic             flag_crc,
    input logic             flag_ovr,
    input logic             eif,
    input logic             irq,
    input logic             dma_req,
    input logic             full,
    input logic             empty,
    input logic [CNT_W-1:0] level,
    input logic             overflow
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (level == '0 && !overflow && !eif));

    a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (pop_byte == 8'd0 && !flag_eof && !flag_crc && !flag_ovr));

    a_r6_irq_gates_dma: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !dma_req);

    a_r7_dma_level: assert property (@(posedge clk) disable iff (!rst_n)
        (level >= CNT_W'(DMA_LEVEL) && !eif) |-> dma_req);

    a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_valid && !pop_req) |=> ($stable(level) && overflow));

    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    a_r9_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && pop_req && !empty) |=> $stable(level));
endmodule

bind tagged_rx_fifo tagged_rx_fifo_chk #(.DEPTH(DEPTH), .DMA_LEVEL(DMA_LEVEL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .pop_byte   (pop_byte),
    .flag_eof   (flag_eof),
    .flag_crc   (flag_crc),
    .flag_ovr   (flag_ovr),
    .eif        (eif),
    .irq        (irq),
    .dma_req    (dma_req),
    .full       (full),
    .empty      (empty),
    .level      (level),
    .overflow   (overflow)
);

// File: tb/tagged_rx_fifo_tb.sv
// Directed bench for tagged_rx_fifo: one task per scenario.
module tagged_rx_fifo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int WIN        = 4;
    localparam int DMA_LEVEL  = 4;
    localparam int CNT_W      = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_valid = 1'b0;
    logic [7:0]       push_byte = '0;
    logic [2:0]       push_tags = '0;
    logic             pop_req = 1'b0;
    logic [7:0]       pop_byte;
    logic             flag_eof, flag_crc, flag_ovr;
    logic             eif, irq, dma_req, full, empty, overflow;
    logic [CNT_W-1:0] level;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tagged_rx_fifo #(.DEPTH(DEPTH), .WIN(WIN), .DMA_LEVEL(DMA_LEVEL)) u_dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_byte(push_byte),
        .push_tags(push_tags), .pop_req(pop_req), .pop_byte(pop_byte),
        .flag_eof(flag_eof), .flag_crc(flag_crc), .flag_ovr(flag_ovr),
        .eif(eif), .irq(irq), .dma_req(dma_req), .full(full), .empty(empty),
        .level(level), .overflow(overflow)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // One clock with the given inputs; returns at the following falling edge.
    task automatic step(input logic w, input logic [7:0] d, input logic [2:0] t, input logic r);
        push_valid = w; push_byte = d; push_tags = t; pop_req = r;
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0; pop_req = 1'b0;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain();
        while (!empty) step(1'b0, 8'd0, 3'd0, 1'b1);
    endtask

    task automatic t_reset();
        check("R1", "level", int'(level), 0);
        check("R1", "empty", int'(empty), 1);
        check("R1", "full", int'(full), 0);
        check("R1", "overflow", int'(overflow), 0);
        check("R1", "eif", int'(eif), 0);
        check("R1", "irq", int'(irq), 0);
        check("R1", "dma_req", int'(dma_req), 0);
        check("R1", "flags", int'({flag_ovr, flag_crc, flag_eof}), 0);
        check("R1", "pop_byte", int'(pop_byte), 0);
    endtask

    task automatic t_order();
        step(1'b1, 8'h11, 3'b000, 1'b0);
        step(1'b1, 8'h22, 3'b001, 1'b0);
        step(1'b1, 8'h33, 3'b000, 1'b0);
        check("R2", "level after 3 pushes", int'(level), 3);
        check("R2", "oldest byte", int'(pop_byte), 'h11);
        check("R3", "eof of clean bottom", int'(flag_eof), 0);
        check("R5", "eif with tag in window", int'(eif), 1);
        check("R6", "irq follows eif", int'(irq), 1);
        step(1'b0, 8'd0, 3'd0, 1'b1);
        check("R2", "second byte", int'(pop_byte), 'h22);
        check("R3", "eof of tagged bottom", int'(flag_eof), 1);
        step(1'b0, 8'd0, 3'd0, 1'b1);
        check("R2", "third byte", int'(pop_byte), 'h33);
        check("R3", "eof cleared after pop", int'(flag_eof), 0);
        check("R5", "eif falls when tag drained", int'(eif), 0);
        step(1'b0, 8'd0, 3'd0, 1'b1);
        check("R2", "empty after pops", int'(empty), 1);
    endtask

    task automatic t_empty();
        step(1'b0, 8'd0, 3'd0, 1'b1);
        check("R4", "level after empty pop", int'(level), 0);
        check("R4", "pop_byte empty", int'(pop_byte), 0);
        check("R4", "flags empty", int'({flag_ovr, flag_crc, flag_eof}), 0);
    endtask

    task automatic t_tags();
        step(1'b1, 8'h5A, 3'b110, 1'b0);
        check("R3", "crc flag", int'(flag_crc), 1);
        check("R3", "ovr flag", int'(flag_ovr), 1);
        check("R3", "eof flag", int'(flag_eof), 0);
        check("R3", "byte with tags", int'(pop_byte), 'h5A);
        step(1'b0, 8'd0, 3'd0, 1'b1);
        check("R3", "flags after pop to empty", int'({flag_ovr, flag_crc, flag_eof}), 0);
    endtask

    task automatic t_window();
        for (int i = 0; i < 4; i++) step(1'b1, 8'(8'h40 + i), 3'b000, 1'b0);
        step(1'b1, 8'h99, 3'b001, 1'b0);
        check("R5", "tag in fifth slot ignored", int'(eif), 0);
        check("R7", "dma at level 5 no tag", int'(dma_req), 1);
        check("R6", "irq low", int'(irq), 0);
        step(1'b0, 8'd0, 3'd0, 1'b1);
        check("R5", "tag enters window", int'(eif), 1);
        check("R6", "dma blocked by eif", int'(dma_req), 0);
        check("R6", "irq raised", int'(irq), 1);
        for (int i = 0; i < 3; i++) step(1'b0, 8'd0, 3'd0, 1'b1);
        check("R3", "tagged entry at bottom", int'(flag_eof), 1);
        check("R2", "tagged byte", int'(pop_byte), 'h99);
        step(1'b0, 8'd0, 3'd0, 1'b1);
        check("R5", "eif clear after drain", int'(eif), 0);
        for (int i = 0; i < 3; i++) step(1'b1, 8'(i), 3'b000, 1'b0);
        check("R7", "dma low below level", int'(dma_req), 0);
        step(1'b1, 8'h03, 3'b000, 1'b0);
        check("R7", "dma resumes at level", int'(dma_req), 1);
        drain();
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'hA0 + i), 3'b000, 1'b0);
        check("R8", "full", int'(full), 1);
        check("R8", "level full", int'(level), DEPTH);
        check("R8", "no overflow yet", int'(overflow), 0);
        step(1'b1, 8'hEE, 3'b100, 1'b0);
        check("R8", "level after drop", int'(level), DEPTH);
        check("R8", "overflow set", int'(overflow), 1);
        check("R8", "dropped tag not stored", int'(eif), 0);
        for (int i = 0; i < DEPTH; i++) begin
            check("R8", "order after drop", int'(pop_byte), 'hA0 + i);
            step(1'b0, 8'd0, 3'd0, 1'b1);
        end
        check("R8", "empty after drain", int'(empty), 1);
        check("R8", "overflow sticky", int'(overflow), 1);
    endtask

    task automatic t_pushpop();
        step(1'b1, 8'h01, 3'b000, 1'b1);
        check("R9", "push+pop on empty stores", int'(level), 1);
        check("R9", "byte stored", int'(pop_byte), 'h01);
        step(1'b1, 8'h02, 3'b000, 1'b0);
        step(1'b1, 8'h03, 3'b000, 1'b1);
        check("R9", "level unchanged", int'(level), 2);
        check("R9", "next byte", int'(pop_byte), 'h02);
        drain();
        for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'hC0 + i), 3'b000, 1'b0);
        step(1'b1, 8'hCF, 3'b000, 1'b1);
        check("R9", "full level kept", int'(level), DEPTH);
        check("R9", "bottom advanced", int'(pop_byte), 'hC1);
        for (int i = 0; i < DEPTH - 1; i++) step(1'b0, 8'd0, 3'd0, 1'b1);
        check("R9", "push at full kept", int'(pop_byte), 'hCF);
        drain();
    endtask

    task automatic t_rereset();
        step(1'b1, 8'h77, 3'b010, 1'b0);
        apply_reset();
        check("R1", "overflow cleared", int'(overflow), 0);
        check("R1", "level cleared", int'(level), 0);
        check("R1", "eif cleared", int'(eif), 0);
    endtask

    initial begin
        apply_reset();
        t_reset();
        t_order();
        t_empty();
        t_tags();
        t_window();
        t_full();
        t_pushpop();
        t_rereset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule